// File: doc/BRIEF.md
# Iterative AES-128 Cipher Engine

This block encrypts or decrypts one 128-bit block under a 128-bit key. The state is split into four 32-bit columns. A single 32-bit column datapath handles one column per clock. That datapath contains four byte substitution units, one forward/inverse column mixer and a round-key XOR. The same four substitution units also serve the key schedule. Each round therefore takes five cycles: one cycle advances the round key, then four cycles process the four columns.

A key is installed with a load strobe. After the strobe, the engine spends ten cycles walking the schedule forward. It keeps the original key and the final round key, so decryption can step the schedule backward from the end without extra cycles per block. A block starts on `start`, with `decrypt` choosing the direction. Four cycles of column-wise initial key whitening and ten five-cycle rounds follow, which makes 54 cycles in all. At the end the result appears on `dout` and `done` pulses.

`start` and `key_load` are plain control strobes sampled only while the engine is idle. `busy` is high throughout key expansion and block processing. There is no back-pressure: `dout` is a held register that the consumer reads when `done` pulses. If `key_load` and `start` arrive together while idle, the key load is taken.

Top module: `aes128_iter`

## Requirements
- R1: A `key_load` pulse while idle stores `key_in`. `busy` is then high for exactly 10 cycles while the final round key is derived.
- R2: With `decrypt`=0, `dout` is the standard AES-128 ciphertext of `din`. Byte order: `din[127:120]` is the first byte. The first 32-bit column is the most significant word, and within a column the row 0 byte is the most significant.
- R3: With `decrypt`=1, `dout` is the AES-128 plaintext of `din` under the stored key, so that decryption undoes R2.
- R4: `done` is high in the cycle after the 54th rising clock edge following the edge that samples `start`. `busy` is high from the cycle after that sampling edge until `done` rises.
- R5: `done` is high for exactly one cycle. `dout` keeps its value from one completion until the next completion, including while the next block is in progress.
- R6: `start` and `key_load` have no effect while `busy` is high. The running block keeps its result and its 54-cycle latency, no second operation follows, and the stored key is unchanged.
- R7: After reset, `busy`, `done` and `dout` are all zero.
- R8: A `start` asserted in the same cycle that `done` is high is accepted and begins a new block.
- R9: After a new key is loaded, both encryption and decryption use that key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| key_load | input | 1 | Store `key_in` and expand it (idle only) |
| key_in | input | 128 | Cipher key |
| start | input | 1 | Begin one block (idle only) |
| decrypt | input | 1 | 1 selects decryption, 0 encryption; sampled with `start` |
| din | input | 128 | Input block; sampled with `start` |
| busy | output | 1 | Key expansion or block in progress |
| done | output | 1 | One-cycle completion pulse |
| dout | output | 128 | Result block, held between completions |

## Verification
The bench builds the engine with its default geometry: four columns of four bytes and ten rounds. This covers the full schedule, including the round constants that wrap through the field reduction (0x1b, 0x36), in both the forward and the backward direction. It also places the 54-cycle block time and the 10-cycle key expansion at the lengths the requirements fix. Three known-answer keys are switched between runs, so key replacement is covered. Strobes are injected mid-block, and a block is started back-to-back off a `done` pulse.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;
  localparam int NROW      = 4;
  localparam int NCOL      = 4;
  localparam int ROUNDS    = 10;
  localparam int SUB_STEPS = NCOL + 1;
  localparam int BLK_CYC   = NCOL + ROUNDS * SUB_STEPS;
  localparam int CI_W      = $clog2(NCOL);
  localparam int LAT_W     = $clog2(BLK_CYC + 1);
  localparam int RND_W     = $clog2(ROUNDS + 1);

  typedef logic [0:NROW-1][7:0] col_t;
  typedef col_t [0:NCOL-1]      blk_t;

  typedef enum logic [1:0] {ST_IDLE, ST_KEXP, ST_WHITE, ST_ROUND} eng_st_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] xt_inv(input logic [7:0] a);
    return a[0] ? ({1'b1, 7'h00} | ((a ^ 8'h1b) >> 1)) : (a >> 1);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  // multiplicative inverse as a^254, zero maps to zero
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] t;
    t = a;
    for (int k = 0; k < 6; k++) t = gmul(gmul(t, t), a);
    return gmul(t, t);
  endfunction

  function automatic logic [7:0] aff_fwd(input logic [7:0] x);
    return x ^ {x[6:0], x[7]} ^ {x[5:0], x[7:6]} ^ {x[4:0], x[7:5]} ^ {x[3:0], x[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] aff_inv(input logic [7:0] x);
    return {x[6:0], x[7]} ^ {x[4:0], x[7:5]} ^ {x[1:0], x[7:2]} ^ 8'h05;
  endfunction

  function automatic logic [7:0] rc_at(input int n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < n; i++) r = xt(r);
    return r;
  endfunction

  localparam logic [7:0] RC_FIRST = 8'h01;
  localparam logic [7:0] RC_LAST  = rc_at(ROUNDS);
endpackage

// File: rtl/aes_sub_byte.sv
module aes_sub_byte
  import aes_iter_pkg::*;
(
  input  logic [7:0] a_i,
  input  logic       inv_i,
  output logic [7:0] y_o
);
  logic [7:0] pre, q;
  // one field inverter serves both directions
  always_comb begin
    pre = inv_i ? aff_inv(a_i) : a_i;
    q   = ginv(pre);
    y_o = inv_i ? q : aff_fwd(q);
  end
endmodule

// File: rtl/aes_col_mix.sv
module aes_col_mix
  import aes_iter_pkg::*;
(
  input  col_t a_i,
  input  logic inv_i,
  output col_t y_o
);
  logic [7:0] u, v;
  col_t p;
  // inverse mix = forward mix of a pre-conditioned column
  always_comb begin
    u = xt(xt(a_i[0] ^ a_i[2]));
    v = xt(xt(a_i[1] ^ a_i[3]));
    p = a_i;
    if (inv_i) begin
      p[0] = a_i[0] ^ u;
      p[1] = a_i[1] ^ v;
      p[2] = a_i[2] ^ u;
      p[3] = a_i[3] ^ v;
    end
    y_o[0] = xt(p[0]) ^ xt(p[1]) ^ p[1] ^ p[2] ^ p[3];
    y_o[1] = p[0] ^ xt(p[1]) ^ xt(p[2]) ^ p[2] ^ p[3];
    y_o[2] = p[0] ^ p[1] ^ xt(p[2]) ^ xt(p[3]) ^ p[3];
    y_o[3] = xt(p[0]) ^ p[0] ^ p[1] ^ p[2] ^ xt(p[3]);
  end
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_iter_pkg::*;
(
  input  blk_t       wk_i,
  input  logic       back_i,
  input  logic [7:0] rc_i,
  output col_t       sb_in_o,
  input  col_t       sb_out_i,
  output blk_t       nxt_o
);
  col_t w3x, t;
  always_comb begin
    w3x     = back_i ? (wk_i[3] ^ wk_i[2]) : wk_i[3];
    sb_in_o = {w3x[1], w3x[2], w3x[3], w3x[0]};
    t       = sb_out_i;
    t[0]    = t[0] ^ rc_i;
    if (back_i) begin
      nxt_o[3] = wk_i[3] ^ wk_i[2];
      nxt_o[2] = wk_i[2] ^ wk_i[1];
      nxt_o[1] = wk_i[1] ^ wk_i[0];
      nxt_o[0] = wk_i[0] ^ t;
    end else begin
      nxt_o[0] = wk_i[0] ^ t;
      nxt_o[1] = wk_i[1] ^ wk_i[0] ^ t;
      nxt_o[2] = wk_i[2] ^ wk_i[1] ^ wk_i[0] ^ t;
      nxt_o[3] = wk_i[3] ^ wk_i[2] ^ wk_i[1] ^ wk_i[0] ^ t;
    end
  end
endmodule

// File: rtl/aes128_iter.sv
module aes128_iter
  import aes_iter_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_load,
  input  logic [127:0] key_in,
  input  logic         start,
  input  logic         decrypt,
  input  logic [127:0] din,
  output logic         busy,
  output logic         done,
  output logic [127:0] dout
);
  eng_st_t          state;
  blk_t             st_q, nx_q, wk_q, key0_q, klast_q;
  logic [7:0]       rc_q;
  logic [2:0]       sub_q;
  logic [RND_W-1:0] rnd_q;
  logic [RND_W-1:0] kcnt_q;
  logic [LAT_W-1:0] lat_q;
  logic             dec_q;

  logic [2:0]       sub_m1;
  logic [CI_W-1:0]  colidx, src;
  logic             key_mode, sb_inv, last_rnd;
  col_t             gath, k_sbin, sb_in, sb_out, mix_in, mix_out, kc, col_res;
  blk_t             k_nxt, st_new;

  assign busy     = (state != ST_IDLE);
  assign sub_m1   = sub_q - 3'd1;
  assign colidx   = (state == ST_ROUND) ? sub_m1[CI_W-1:0] : sub_q[CI_W-1:0];
  assign key_mode = (state == ST_KEXP) || (state == ST_ROUND && sub_q == 3'd0);
  assign sb_inv   = dec_q && (state == ST_ROUND) && (sub_q != 3'd0);
  assign last_rnd = (rnd_q == RND_W'(ROUNDS));
  assign kc       = wk_q[colidx];

  // row r of output column c comes from column c+r (forward) or c-r (inverse)
  always_comb begin
    gath = '0;
    src  = '0;
    for (int i = 0; i < NROW; i++) begin
      src     = dec_q ? colidx - CI_W'(i) : colidx + CI_W'(i);
      gath[i] = st_q[src][i];
    end
  end

  assign sb_in = key_mode ? k_sbin : gath;

  for (genvar g = 0; g < NROW; g++) begin : g_sbox
    aes_sub_byte u_sb (.a_i(sb_in[g]), .inv_i(sb_inv), .y_o(sb_out[g]));
  end

  aes_key_step u_ks (
    .wk_i    (wk_q),
    .back_i  (dec_q && state == ST_ROUND),
    .rc_i    (rc_q),
    .sb_in_o (k_sbin),
    .sb_out_i(sb_out),
    .nxt_o   (k_nxt)
  );

  assign mix_in = dec_q ? (sb_out ^ kc) : sb_out;

  aes_col_mix u_mx (.a_i(mix_in), .inv_i(dec_q), .y_o(mix_out));

  always_comb begin
    if (state == ST_WHITE)  col_res = st_q[colidx] ^ kc;
    else if (dec_q)         col_res = last_rnd ? (sb_out ^ kc) : mix_out;
    else                    col_res = (last_rnd ? sb_out : mix_out) ^ kc;
    st_new = {nx_q[0], nx_q[1], nx_q[2], col_res};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      st_q    <= '0;
      nx_q    <= '0;
      wk_q    <= '0;
      key0_q  <= '0;
      klast_q <= '0;
      rc_q    <= RC_FIRST;
      sub_q   <= '0;
      rnd_q   <= '0;
      kcnt_q  <= '0;
      dec_q   <= 1'b0;
      done    <= 1'b0;
      dout    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (key_load) begin
            key0_q <= key_in;
            wk_q   <= key_in;
            rc_q   <= RC_FIRST;
            kcnt_q <= '0;
            state  <= ST_KEXP;
          end else if (start) begin
            st_q  <= din;
            dec_q <= decrypt;
            wk_q  <= decrypt ? klast_q : key0_q;
            rc_q  <= decrypt ? RC_LAST : RC_FIRST;
            sub_q <= '0;
            state <= ST_WHITE;
          end
        end
        ST_KEXP: begin
          wk_q   <= k_nxt;
          rc_q   <= xt(rc_q);
          kcnt_q <= kcnt_q + 1'b1;
          if (kcnt_q == RND_W'(ROUNDS - 1)) begin
            klast_q <= k_nxt;
            state   <= ST_IDLE;
          end
        end
        ST_WHITE: begin
          nx_q[colidx] <= col_res;
          if (sub_q == 3'(NCOL - 1)) begin
            st_q  <= st_new;
            sub_q <= '0;
            rnd_q <= RND_W'(1);
            state <= ST_ROUND;
          end else begin
            sub_q <= sub_q + 3'd1;
          end
        end
        ST_ROUND: begin
          if (sub_q == 3'd0) begin
            wk_q  <= k_nxt;
            rc_q  <= dec_q ? xt_inv(rc_q) : xt(rc_q);
            sub_q <= 3'd1;
          end else begin
            nx_q[colidx] <= col_res;
            if (sub_q == 3'(NCOL)) begin
              st_q  <= st_new;
              sub_q <= '0;
              if (last_rnd) begin
                dout  <= st_new;
                done  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                rnd_q <= rnd_q + 1'b1;
              end
            end else begin
              sub_q <= sub_q + 3'd1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // cycle counter for the checks below
  always_ff @(posedge clk) begin
    if (!rst_n || state == ST_IDLE) lat_q <= '0;
    else                            lat_q <= lat_q + 1'b1;
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dout));
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LAT_W'(BLK_CYC)));
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (start || key_load)) |=> (lat_q == $past(lat_q) + 1'b1));
  p_kexp_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_KEXP) |-> (lat_q < LAT_W'(ROUNDS)));
endmodule

// File: tb/sim_aes128_iter.sv
module sim_aes128_iter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_load = 1'b0;
  logic [127:0] key_in = '0;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic [127:0] din = '0;
  logic         busy, done;
  logic [127:0] dout;

  int checks = 0;
  int errs   = 0;

  always #5 clk = ~clk;

  aes128_iter u0 (.*);

  // key, plaintext, ciphertext
  localparam logic [383:0] VEC [3] = '{
    {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, 128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734, 128'h3925841d02dc09fbdc118597196a0b32},
    {128'h00000000000000000000000000000000, 128'h00000000000000000000000000000000, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
  };

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [127:0] k, output int n);
    @(negedge clk); key_load = 1'b1; key_in = k;
    @(negedge clk); key_load = 1'b0;
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
  endtask

  // imm: assert start at the current negedge (caller is at the done cycle)
  task automatic run_block(input logic imm, input logic dec, input logic [127:0] d, input logic disturb,
                           output logic [127:0] res, output int lat, output logic [127:0] mid);
    if (!imm) @(negedge clk);
    start = 1'b1; decrypt = dec; din = d;
    @(negedge clk); start = 1'b0;
    lat = 0; mid = dout;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      if (lat == 30) mid = dout;
      if (disturb && lat == 20) begin
        start = 1'b1; key_load = 1'b1; decrypt = ~dec; din = ~d; key_in = ~key_in;
      end else begin
        start = 1'b0; key_load = 1'b0;
      end
    end
    decrypt = dec;
    res = dout;
  endtask

  initial begin
    logic [127:0] r, m, k, p, c, prev;
    int lat, n;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(busy == 1'b0, "R7 busy", 128'(busy), 128'h0);
    chk(done == 1'b0, "R7 done", 128'(done), 128'h0);
    chk(dout == '0, "R7 dout", dout, 128'h0);
    rst_n = 1'b1;

    for (int v = 0; v < 3; v++) begin
      {k, p, c} = VEC[v];
      do_load(k, n);
      chk(n == 10, "R1 key expansion cycles", 128'(n), 128'd10);
      run_block(1'b0, 1'b0, p, 1'b0, r, lat, m);
      chk(r == c, "R2 encrypt", r, c);
      chk(lat == 54, "R4 encrypt latency", 128'(lat), 128'd54);
      @(negedge clk);
      chk(done == 1'b0, "R5 done width", 128'(done), 128'h0);
      run_block(1'b0, 1'b1, c, 1'b0, r, lat, m);
      chk(r == p, "R3/R9 decrypt with new key", r, p);
      chk(lat == 54, "R4 decrypt latency", 128'(lat), 128'd54);
    end

    // R5 hold across idle cycles and through the next block
    {k, p, c} = VEC[2];
    prev = dout;
    repeat (5) @(negedge clk);
    chk(dout == prev, "R5 hold idle", dout, prev);
    run_block(1'b0, 1'b0, p, 1'b0, r, lat, m);
    chk(m == prev, "R5 hold during next block", m, prev);

    // R6 strobes during a busy block
    {k, p, c} = VEC[1];
    do_load(k, n);
    key_in = k;
    run_block(1'b0, 1'b0, p, 1'b1, r, lat, m);
    chk(r == c, "R6 result undisturbed", r, c);
    chk(lat == 54, "R6 latency undisturbed", 128'(lat), 128'd54);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy || done) n++;
    end
    chk(n == 0, "R6 no second operation", 128'(n), 128'h0);
    run_block(1'b0, 1'b1, c, 1'b0, r, lat, m);
    chk(r == p, "R6 stored key unchanged", r, p);

    // R8 back-to-back start on the done cycle
    run_block(1'b0, 1'b0, p, 1'b0, r, lat, m);
    chk(r == c, "R8 first block", r, c);
    run_block(1'b1, 1'b1, c, 1'b0, r, lat, m);
    chk(r == p, "R8 back-to-back block", r, p);
    chk(lat == 54, "R8 back-to-back latency", 128'(lat), 128'd54);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule